// File: doc/BRIEF.md
# Modem Line Change Detector

This block watches four active-low modem handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) and presents an eight-bit read-only status byte to a host. Each input is first passed through a synchroniser. The upper nibble of the status byte shows the present, active-high level of each line. The lower nibble holds sticky change flags. A flag goes high when its line has toggled in either direction, and it stays high until the host reads the status byte.

The host reads with a single-cycle strobe. The byte on `stat_o` during that strobe cycle is the value read. On the next edge every change flag is cleared, except a flag whose line changed in that same cycle. An interrupt output is high while any change flag is set and the modem-interrupt bit of the host's interrupt-enable byte is 1.

Top module: `mdm_delta_tracker`

## Requirements
- R1: While reset is asserted and after its release with all lines held high (inactive), `stat_o` reads 8'h00 and `irq_o` is 0.
- R2: `stat_o[4+i]` is the complement of `line_n_i[i]` as sampled two rising edges earlier. The line order is bit 0 CTS, bit 1 DSR, bit 2 RI, bit 3 CD, so status bits 4..7 are CTS, DSR, RI, CD.
- R3: Change flag `stat_o[i]` (bit 0 for CTS) goes to 1 on the third rising edge after `line_n_i[i]` changes level. A change in either direction sets it.
- R4: A set change flag stays set, even if its line later returns to its earlier level, for as long as no read strobe is given.
- R5: A one-cycle `stat_rd_i` pulse clears all change flags on the next rising edge. The upper nibble is not affected by the read.
- R6: A change that is detected in the same cycle as a read strobe leaves its flag set after the read, while the other flags clear.
- R7: `irq_o` is 1 exactly when at least one change flag is set and `ien_i[3]` is 1. The other bits of `ien_i` have no effect on `irq_o`.
- R8: `irq_o` returns to 0 on the edge where a read clears the last set change flag.
- R9: With all lines held at a constant level, no change flag becomes set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_n_i | input | 4 | Active-low modem lines: [0] CTS, [1] DSR, [2] RI, [3] CD |
| stat_rd_i | input | 1 | Single-cycle host read strobe for the status byte |
| ien_i | input | 8 | Host interrupt-enable byte; bit 3 enables the modem interrupt |
| stat_o | output | 8 | Status: [7:4] current line levels (active high), [3:0] sticky change flags |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a line change that the block detects in exactly the same cycle as a host read. Because of the synchroniser delay, the strobe has to land two edges after the line moved, while a different flag is already set. A directed sequence builds this case deliberately: it first sets the CTS flag, then toggles DSR and issues the read after exactly two edges, and checks that only the DSR flag survives. Random traffic then mixes sparse line toggles, frequent reads and random enable bytes against a cycle model, so further coincidences of this kind also occur.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   // Line positions inside the line vector and the status nibbles.
   localparam int unsigned LINE_CTS = 0;
   localparam int unsigned LINE_DSR = 1;
   localparam int unsigned LINE_RI  = 2;
   localparam int unsigned LINE_CD  = 3;
   localparam int unsigned LINE_CNT = 4;

   // Position of the modem-interrupt enable inside the enable byte.
   localparam int unsigned IEN_MODEM_BIT = 3;
   localparam int unsigned IEN_WIDTH     = 8;

   typedef logic [LINE_CNT-1:0] line_vec_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int unsigned WIDTH   = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mdm_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mdm_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= RST_VAL;
            else        stg_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= RST_VAL;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_delta_latch.sv
module mdm_delta_latch #(
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic clr_i,
   output logic delta_o
);
   logic last_q;
   logic flag_q;
   logic moved;

   assign moved = lvl_i ^ last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= IDLE_LVL;
         flag_q <= 1'b0;
      end else begin
         last_q <= lvl_i;
         // a fresh move wins over a clear in the same cycle
         flag_q <= (flag_q & ~clr_i) | moved;
      end
   end

   assign delta_o = flag_q;
endmodule

// File: rtl/mdm_irq_gen.sv
module mdm_irq_gen #(
   parameter int unsigned FLAGS  = 4,
   parameter int unsigned IEN_W  = 8,
   parameter int unsigned EN_BIT = 3
) (
   input  logic [FLAGS-1:0] flag_i,
   input  logic [IEN_W-1:0] ien_i,
   output logic             irq_o
);
   if (EN_BIT >= IEN_W) begin : g_bad_bit
      $error("mdm_irq_gen: EN_BIT outside enable byte");
   end

   assign irq_o = (|flag_i) & ien_i[EN_BIT];
endmodule

// File: rtl/mdm_delta_tracker.sv
module mdm_delta_tracker #(
   parameter int unsigned NUM_LINES   = mdm_pkg::LINE_CNT,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IEN_W       = mdm_pkg::IEN_WIDTH,
   parameter int unsigned IEN_BIT     = mdm_pkg::IEN_MODEM_BIT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_LINES-1:0]   line_n_i,
   input  logic                   stat_rd_i,
   input  logic [IEN_W-1:0]       ien_i,
   output logic [2*NUM_LINES-1:0] stat_o,
   output logic                   irq_o
);
   localparam int unsigned STAT_W = 2 * NUM_LINES;

   if (NUM_LINES < 1) begin : g_bad_lines
      $error("mdm_delta_tracker: NUM_LINES must be at least 1");
   end

   logic [NUM_LINES-1:0] line_sync_n;
   logic [NUM_LINES-1:0] delta;

   mdm_sync #(
      .WIDTH   (NUM_LINES),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({NUM_LINES{1'b1}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (line_n_i),
      .q_o   (line_sync_n)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      mdm_delta_latch #(
         .IDLE_LVL (1'b1)
      ) u_latch (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_i   (line_sync_n[i]),
         .clr_i   (stat_rd_i),
         .delta_o (delta[i])
      );
   end

   mdm_irq_gen #(
      .FLAGS  (NUM_LINES),
      .IEN_W  (IEN_W),
      .EN_BIT (IEN_BIT)
   ) u_irq (
      .flag_i (delta),
      .ien_i  (ien_i),
      .irq_o  (irq_o)
   );

   assign stat_o[STAT_W-1:NUM_LINES] = ~line_sync_n;
   assign stat_o[NUM_LINES-1:0]      = delta;
endmodule

// File: rtl/mdm_delta_tracker_chk.sv
module mdm_delta_tracker_chk #(
   parameter int unsigned NUM_LINES   = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IEN_W       = 8,
   parameter int unsigned IEN_BIT     = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_LINES-1:0]   line_n_i,
   input logic                   stat_rd_i,
   input logic [IEN_W-1:0]       ien_i,
   input logic [2*NUM_LINES-1:0] stat_o,
   input logic                   irq_o
);
   localparam int unsigned N = NUM_LINES;

   logic [1:0] warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             warm_q <= '0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
   end

   // R1: change flags are clear while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_clear: assert (stat_o[N-1:0] == '0 && !irq_o);
      end
   end

   // R2: upper nibble follows the inverted line two edges late
   if (SYNC_STAGES == 2) begin : g_lat
      a_r2_level_view: assert property (@(posedge clk) disable iff (!rst_n)
         (warm_q >= 2'd2) |-> (stat_o[2*N-1:N] == ~$past(line_n_i, 2)));
   end

   // R3: every level move of the view is followed by its flag
   for (genvar i = 0; i < N; i++) begin : g_bit
      a_r3_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_o[N+i] != $past(stat_o[N+i])) |=> stat_o[i]);
   end

   // R4: without a read, no flag falls
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd_i |=> (($past(stat_o[N-1:0]) & ~stat_o[N-1:0]) == '0));

   // R5 / R6: after a read only same-cycle changes survive
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd_i |=> (stat_o[N-1:0] ==
                     ($past(stat_o[2*N-1:N]) ^ $past(stat_o[2*N-1:N], 2))));

   // R7: interrupt tracks flags and the enable bit
   a_r7_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
      ((|stat_o[N-1:0]) && ien_i[IEN_BIT]) |-> irq_o);
   a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((|stat_o[N-1:0]) && ien_i[IEN_BIT]));
endmodule

bind mdm_delta_tracker mdm_delta_tracker_chk #(
   .NUM_LINES   (NUM_LINES),
   .SYNC_STAGES (SYNC_STAGES),
   .IEN_W       (IEN_W),
   .IEN_BIT     (IEN_BIT)
) u_chk (.*);

// File: tb/mdm_delta_tracker_bench.sv
`timescale 1ns/1ps
module mdm_delta_tracker_bench;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] line_n = '1;
   logic         rd = 1'b0;
   logic [7:0]   ien = 8'h00;
   logic [7:0]   stat;
   logic         irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   mdm_delta_tracker u_mdm_delta_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_n_i  (line_n),
      .stat_rd_i (rd),
      .ien_i     (ien),
      .stat_o    (stat),
      .irq_o     (irq)
   );

   // Cycle model built from R2/R3/R5/R6
   logic [N-1:0] m_s1, m_s2, m_prev, m_flag;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '1; m_s2 <= '1; m_prev <= '1; m_flag <= '0;
      end else begin
         m_s1   <= line_n;
         m_s2   <= m_s1;
         m_prev <= m_s2;
         m_flag <= (m_flag & ~{N{rd}}) | (m_s2 ^ m_prev);
      end
   end

   function automatic logic [7:0] exp_stat();
      return {~m_s2, m_flag};
   endfunction

   function automatic logic exp_irq(input logic [7:0] s, input logic [7:0] en);
      return (|s[3:0]) & en[3];
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_all();
      @(negedge clk); rd = 1'b1;
      @(negedge clk); rd = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      ien = 8'h08;
      repeat (3) @(negedge clk);
      chk(stat == 8'h00, "R1 stat in reset", stat, 8'h00);
      chk(irq == 1'b0, "R1 irq in reset", irq, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(stat == 8'h00, "R1 stat after reset", stat, 8'h00);

      // R2 R3 R4 R5 R7 R8 per line
      for (int i = 0; i < N; i++) begin
         @(negedge clk); line_n[i] = 1'b0; ien = 8'h00;
         @(posedge clk); @(posedge clk); @(negedge clk);
         chk(stat[4+i] == 1'b1, "R2 level bit", stat, 8'h10 << i);
         chk(stat[i] == 1'b0, "R3 flag not early", stat, 8'h10 << i);
         @(negedge clk);
         chk(stat == ((8'h11) << i), "R3 flag set", stat, 8'h11 << i);
         chk(irq == 1'b0, "R7 enable low", irq, 0);
         ien = 8'hF7; #1;
         chk(irq == 1'b0, "R7 other enable bits", irq, 0);
         ien = 8'h08; #1;
         chk(irq == 1'b1, "R7 irq raised", irq, 1);
         line_n[i] = 1'b1;
         repeat (4) @(negedge clk);
         chk(stat == (8'h01 << i), "R4 flag sticky", stat, 8'h01 << i);
         rd = 1'b1;
         @(negedge clk); rd = 1'b0;
         chk(stat == 8'h00, "R5 read clears", stat, 8'h00);
         chk(irq == 1'b0, "R8 irq drops", irq, 0);
      end

      // R6: DSR change lands in the read cycle, CTS flag was set
      @(negedge clk); line_n[0] = 1'b0;
      repeat (4) @(negedge clk);
      chk(stat[3:0] == 4'b0001, "R6 setup", stat, 8'h11);
      line_n[1] = 1'b0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      rd = 1'b1;
      @(negedge clk); rd = 1'b0;
      chk(stat == 8'h32, "R6 same-cycle change kept", stat, 8'h32);
      chk(irq == 1'b1, "R7 irq kept", irq, 1);

      // R9: lines steady, nothing appears
      clear_all();
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk(stat[3:0] == 4'h0, "R9 no spurious flag", stat, 8'h30);
      end

      // random phase against the model
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         chk(stat == exp_stat(), "R2/R3/R4/R5/R6 model", stat, exp_stat());
         chk(irq == exp_irq(stat, ien), "R7/R8 model", irq, exp_irq(stat, ien));
         for (int b = 0; b < N; b++)
            if ($urandom % 12 == 0) line_n[b] = ~line_n[b];
         rd  = ($urandom % 5 == 0);
         ien = 8'($urandom);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule